// File: doc/BRIEF.md
# I2C Pass-Code Unlock Detector

This block sits behind an I2C byte-level receiver. It watches the bus events that the receiver decodes: a START, each received byte and a STOP. It raises a sticky control-mode flag only when one exact unlock write has finished. That write is a block write to a fixed slave address with a fixed command byte, followed by a two-byte pass code, and it must close with a STOP. Byte decoding on the wires, and what the unlocked mode permits, are handled elsewhere.

An attempt counts as begun once the address byte after a START matches the unlock address. From then on, any deviation abandons the attempt, and the block pulses a failure status for one cycle. Deviations are a wrong byte, an extra byte, a STOP too early, or a repeated START. After that the block waits for a fresh START. Traffic to any other address, including the same device with the read bit set, is ignored and reports nothing.

Top module: `unlock_detector`

## Requirements
- R1: While reset (`rstN` low, synchronous) is applied and in the first cycle after it, `ctrlEnabled` and `attemptFailed` are 0.
- R2: An event is taken when `evValid` is 1. `evKind` 0 is START, 1 is a received byte on `evData`, 2 is STOP, and 3 is ignored. The first byte after a START is the address byte. A START that follows a START with no byte in between simply restarts the transaction.
- R3: The sequence START, 0x22, 0x81, 0xF4, 0x4F, STOP sets `ctrlEnabled` to 1 in the cycle after the STOP event is taken.
- R4: `ctrlEnabled` stays 0 after the last pass-code byte until the STOP is taken.
- R5: Once the address has matched, a wrong command byte or a wrong pass-code byte pulses `attemptFailed`. A STOP that follows does not unlock.
- R6: The pass-code bytes in swapped order (0x4F then 0xF4) fail and do not unlock.
- R7: A further byte after the second pass-code byte fails the attempt, and the following STOP does not unlock.
- R8: A START after the address has matched and before the closing STOP fails the attempt. This includes a START in place of the STOP. The block then ignores all bytes and STOPs until the next START.
- R9: A STOP that arrives after a matched address but before the sequence is complete fails the attempt without unlocking.
- R10: An address byte other than 0x22 (for example 0x20, or 0x23 with the read bit) causes neither a failure pulse nor an unlock, whatever follows up to the next START.
- R11: Once set, `ctrlEnabled` stays 1 through any later events and is cleared only by reset.
- R12: `attemptFailed` is high for exactly the one cycle after the offending event is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| evValid | input | 1 | Event strobe from the byte-level receiver |
| evKind | input | 2 | Event type: 0 START, 1 byte, 2 STOP, 3 none |
| evData | input | 8 | Received byte, meaningful when evKind is 1 |
| ctrlEnabled | output | 1 | Sticky control-mode enable |
| attemptFailed | output | 1 | One-cycle pulse on an abandoned unlock attempt |

## Verification
The bench builds the block with its default parameters. These are the 0x22 address, the 0x81 command and the two-byte code 0xF4 0x4F, so the match index covers four positions and reaches its last one. With these values, every branch of the sequence can be reached with short event streams. The branches are a swapped code, a truncated write, an extra byte, a START in place of the STOP, and an early restart. The streams also cover foreign addresses, the read-bit address, ignored event codes and the sticky flag across later failures.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

  typedef enum logic [1:0] {
    EV_START = 2'd0,
    EV_BYTE  = 2'd1,
    EV_STOP  = 2'd2,
    EV_NONE  = 2'd3
  } evKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrIdx;
    logic incIdx;
    logic setEn;
    logic fail;
  } ctrlStrb_t;

  // status from datapath to control
  typedef struct packed {
    logic byteMatch;
    logic atFirst;
    logic atLast;
  } dpStat_t;

endpackage

// File: rtl/unlock_datapath.sv
module unlock_datapath
  import unlock_pkg::*;
#(
  parameter logic [7:0] UNLOCK_ADDR = 8'h22,
  parameter logic [7:0] UNLOCK_CMD  = 8'h81,
  parameter int         PASS_LEN    = 2,
  parameter logic [PASS_LEN*8-1:0] PASS_CODE = 16'hF44F
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic [7:0] evData,
  input  ctrlStrb_t strb,
  output dpStat_t   stat,
  output logic      ctrlEnabled,
  output logic      attemptFailed
);

  localparam int SEQ_LEN = PASS_LEN + 2;
  localparam int IDX_W   = $clog2(SEQ_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);
  localparam logic [SEQ_LEN*8-1:0] SEQ_BYTES = {UNLOCK_ADDR, UNLOCK_CMD, PASS_CODE};

  logic [7:0]       expByte [SEQ_LEN];
  logic [IDX_W-1:0] idx;

  genvar gi;
  generate
    for (gi = 0; gi < SEQ_LEN; gi++) begin : g_seq
      assign expByte[gi] = SEQ_BYTES[(SEQ_LEN-1-gi)*8 +: 8];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx <= '0;
    end else if (strb.clrIdx) begin
      idx <= '0;
    end else if (strb.incIdx) begin
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlEnabled   <= 1'b0;
      attemptFailed <= 1'b0;
    end else begin
      if (strb.setEn) ctrlEnabled <= 1'b1;
      attemptFailed <= strb.fail;
    end
  end

  always_comb begin
    stat.byteMatch = (evData == expByte[idx]);
    stat.atFirst   = (idx == '0);
    stat.atLast    = (idx == LAST_IDX);
  end

  p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    idx <= LAST_IDX);

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctrlEnabled |=> ctrlEnabled);

  p_fail_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    attemptFailed |=> !attemptFailed);

  p_no_fail_on_unlock_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlEnabled) |-> !attemptFailed);

endmodule

// File: rtl/unlock_control.sv
module unlock_control
  import unlock_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evValid,
  input  logic [1:0] evKind,
  input  dpStat_t    stat,
  output ctrlStrb_t  strb
);

  typedef enum logic [1:0] {
    S_WAIT_START = 2'd0,
    S_COLLECT    = 2'd1,
    S_WAIT_STOP  = 2'd2
  } state_t;

  state_t state, nxt;
  logic isStart, isByte, isStop;

  assign isStart = evValid && (evKind == EV_START);
  assign isByte  = evValid && (evKind == EV_BYTE);
  assign isStop  = evValid && (evKind == EV_STOP);

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_WAIT_START;
    else       state <= nxt;
  end

  always_comb begin
    strb = '0;
    nxt  = state;
    unique case (state)
      S_WAIT_START: begin
        if (isStart) begin
          strb.clrIdx = 1'b1;
          nxt         = S_COLLECT;
        end
      end
      S_COLLECT: begin
        if (isStart) begin
          if (stat.atFirst) begin
            strb.clrIdx = 1'b1;
          end else begin
            strb.fail = 1'b1;
            nxt       = S_WAIT_START;
          end
        end else if (isByte) begin
          if (stat.byteMatch) begin
            if (stat.atLast) nxt = S_WAIT_STOP;
            else             strb.incIdx = 1'b1;
          end else begin
            strb.fail = !stat.atFirst;
            nxt       = S_WAIT_START;
          end
        end else if (isStop) begin
          strb.fail = !stat.atFirst;
          nxt       = S_WAIT_START;
        end
      end
      S_WAIT_STOP: begin
        if (isStop) begin
          strb.setEn = 1'b1;
          nxt        = S_WAIT_START;
        end else if (isStart || isByte) begin
          strb.fail = 1'b1;
          nxt       = S_WAIT_START;
        end
      end
      default: nxt = S_WAIT_START;
    endcase
  end

  p_unlock_after_full_seq_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.setEn |-> $past(state == S_COLLECT || state == S_WAIT_STOP));

  p_no_fail_while_waiting_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT_START) |-> !strb.fail);

endmodule

// File: rtl/unlock_detector.sv
module unlock_detector
  import unlock_pkg::*;
#(
  parameter logic [7:0] UNLOCK_ADDR = 8'h22,
  parameter logic [7:0] UNLOCK_CMD  = 8'h81,
  parameter int         PASS_LEN    = 2,
  parameter logic [PASS_LEN*8-1:0] PASS_CODE = 16'hF44F
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       evValid,
  input  logic [1:0] evKind,
  input  logic [7:0] evData,
  output logic       ctrlEnabled,
  output logic       attemptFailed
);

  ctrlStrb_t strb;
  dpStat_t   stat;

  unlock_control u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .evValid (evValid),
    .evKind  (evKind),
    .stat    (stat),
    .strb    (strb)
  );

  unlock_datapath #(
    .UNLOCK_ADDR (UNLOCK_ADDR),
    .UNLOCK_CMD  (UNLOCK_CMD),
    .PASS_LEN    (PASS_LEN),
    .PASS_CODE   (PASS_CODE)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .evData        (evData),
    .strb          (strb),
    .stat          (stat),
    .ctrlEnabled   (ctrlEnabled),
    .attemptFailed (attemptFailed)
  );

  p_rise_on_stop_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlEnabled) |-> $past(evValid && evKind == 2'd2));

endmodule

// File: tb/tb_unlock_detector.sv
`timescale 1ns/1ps
module tb_unlock_detector;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       evValid = 1'b0;
  logic [1:0] evKind = 2'd3;
  logic [7:0] evData = 8'h00;
  logic       ctrlEnabled, attemptFailed;

  int checks = 0;
  int errors = 0;
  logic [1:0] expQ[$];
  string      tagQ[$];

  always #4 clk = ~clk;

  unlock_detector dut (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evKind(evKind), .evData(evData),
    .ctrlEnabled(ctrlEnabled), .attemptFailed(attemptFailed)
  );

  task automatic compare(input logic expEn, input logic expFail, input string tag);
    checks++;
    if (ctrlEnabled !== expEn || attemptFailed !== expFail) begin
      errors++;
      $display("FAIL %s: got en=%b fail=%b, expected en=%b fail=%b",
               tag, ctrlEnabled, attemptFailed, expEn, expFail);
    end
  endtask

  // driver: one event (or idle when v=0) per cycle, expectation queued
  task automatic drive(input logic v, input logic [1:0] k, input logic [7:0] d,
                       input logic expEn, input logic expFail, input string tag);
    @(negedge clk);
    evValid = v; evKind = k; evData = d;
    expQ.push_back({expEn, expFail});
    tagQ.push_back(tag);
  endtask

  task automatic st(input logic e, input logic f, input string t); drive(1'b1, 2'd0, 8'h00, e, f, t); endtask
  task automatic by(input logic [7:0] d, input logic e, input logic f, input string t); drive(1'b1, 2'd1, d, e, f, t); endtask
  task automatic sp(input logic e, input logic f, input string t); drive(1'b1, 2'd2, 8'h00, e, f, t); endtask
  task automatic idle(input logic e, input string t); drive(1'b0, 2'd3, 8'h00, e, 1'b0, t); endtask

  // monitor: compares after each edge that consumed a driven item
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        logic [1:0] ex;
        string t;
        ex = expQ.pop_front();
        t  = tagQ.pop_front();
        compare(ex[1], ex[0], t);
      end
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(1'b0, 1'b0, "R1 during reset");
    rstN = 1'b1;
    @(negedge clk);
    compare(1'b0, 1'b0, "R1 after reset");

    // R10: foreign address and read-bit address ignored
    st(0,0,"R10"); by(8'h20,0,0,"R10 addr 0x20"); by(8'h81,0,0,"R10"); by(8'hF4,0,0,"R10"); by(8'h4F,0,0,"R10"); sp(0,0,"R10 stop");
    st(0,0,"R10"); by(8'h23,0,0,"R10 addr 0x23"); by(8'h81,0,0,"R10"); by(8'hF4,0,0,"R10"); by(8'h4F,0,0,"R10"); sp(0,0,"R10 stop");

    // R6: swapped pass code
    st(0,0,"R6"); by(8'h22,0,0,"R6"); by(8'h81,0,0,"R6"); by(8'h4F,0,1,"R6 swapped"); idle(0,"R12 pulse ends");
    by(8'hF4,0,0,"R6"); sp(0,0,"R6 stop");

    // R5: wrong command byte
    st(0,0,"R5"); by(8'h22,0,0,"R5"); by(8'h01,0,1,"R5 bad cmd"); sp(0,0,"R5 stop");

    // R9: truncated write
    st(0,0,"R9"); by(8'h22,0,0,"R9"); by(8'h81,0,0,"R9"); by(8'hF4,0,0,"R9"); sp(0,1,"R9 early stop");

    // R7: extra data byte
    st(0,0,"R7"); by(8'h22,0,0,"R7"); by(8'h81,0,0,"R7"); by(8'hF4,0,0,"R7"); by(8'h4F,0,0,"R4 no early unlock");
    by(8'h4F,0,1,"R7 extra byte"); sp(0,0,"R7 stop");

    // R8: START instead of STOP, then ignored until next START
    st(0,0,"R8"); by(8'h22,0,0,"R8"); by(8'h81,0,0,"R8"); by(8'hF4,0,0,"R8"); by(8'h4F,0,0,"R8");
    st(0,1,"R8 missing stop");
    by(8'h22,0,0,"R8 ignored"); by(8'h81,0,0,"R8 ignored"); by(8'hF4,0,0,"R8 ignored"); by(8'h4F,0,0,"R8 ignored"); sp(0,0,"R8 ignored stop");

    // R8: early repeated START
    st(0,0,"R8"); by(8'h22,0,0,"R8"); by(8'h81,0,0,"R8"); st(0,1,"R8 early restart"); sp(0,0,"R8 stop");

    // R2/R3/R4: correct unlock with a no-op event and a double START
    st(0,0,"R2"); drive(1'b1, 2'd3, 8'h22, 0, 0, "R2 kind3 ignored"); st(0,0,"R2 double start");
    by(8'h22,0,0,"R3"); by(8'h81,0,0,"R3"); by(8'hF4,0,0,"R3"); by(8'h4F,0,0,"R4 before stop");
    idle(0,"R4 waiting"); sp(1,0,"R3 unlock");

    // R11: sticky across later traffic and failures
    idle(1,"R11"); st(1,0,"R11"); by(8'h22,1,0,"R11"); by(8'h01,1,1,"R11 fail while enabled");
    sp(1,0,"R11 stop"); idle(1,"R11");
    @(negedge clk); evValid = 1'b0;
    repeat (3) @(negedge clk);

    // R11/R1: reset clears
    rstN = 1'b0;
    @(negedge clk);
    compare(1'b0, 1'b0, "R11 cleared by reset");
    rstN = 1'b1;
    @(negedge clk);
    compare(1'b0, 1'b0, "R1 after second reset");

    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

endmodule